// File: doc/BRIEF.md
# CompactFlash True IDE PIO Cycle Controller

This block runs single programmed-I/O read and write cycles against a CompactFlash card wired in True IDE mode. A host issues one request at a time with an address, a direction and a width. The block decodes the upper address bits to pick the task-file window or the alternate control window. It then drives the matching chip select, the three register-index lines and one read or write strobe. In this wiring the data register and the 8-bit task-file registers share one index. They are told apart only by the width flag, which the block brings out to the card-side width logic.

Every cycle has four phases, each counted in clocks: setup, strobe pulse, the rest of the total cycle, and a data-float gap after reads. Setup, pulse and cycle counts are loaded from the host. The float count and the IORDY wait policy are derived inside the block from the selected PIO mode and two device capability flags. While waiting is enabled, a low IORDY (after a two-flop synchronizer) freezes the strobe phase. The request port is valid/ready. The host raises `req_valid` and must hold it, with all request fields stable, until it sees `req_ready` high for one clock. The block never asserts `req_ready` unless a request is pending. Read data sits on `rsp_rdata` from the acknowledge clock until the next read completes.

Top module: `cfide_ctrl`

## Requirements
- R1: Address bits [23:21] equal to 3'b110 select the task-file window (`cf_cs0_n` low). 3'b111 selects the alternate window (`cf_cs1_n` low). Bits [2:0] appear on `cf_reg` during the cycle. Any other value is acknowledged without asserting a chip select or strobe, and such a read returns 0x0000.
- R2: With `req_wide`=1 the cycle is 16-bit: `cf_wide` is high, all 16 bits are written, and all 16 bits of `cf_din` are returned. With `req_wide`=0, `cf_wide` is low, `cf_dout[15:8]` is zero and the returned upper byte is zero. `cf_doe` is high only during write cycles.
- R3: The chip select goes low in the clock after the request is accepted. It stays low for max(C, S+P) clocks plus any IORDY wait clocks.
- R4: After S clocks of chip select, the strobe (`cf_rd_n` for reads, `cf_wr_n` for writes) is low for P clocks. A pulse count of zero is treated as one. The other strobe stays high.
- R5: `req_ready` is high for exactly one clock, the clock after the chip select returns high. For a read, `rsp_rdata` then holds the `cf_din` value present in the last strobe clock.
- R6: After a mapped read, the next chip select with a request already waiting follows F+2 high clocks, where F = ceil(30 ns × clock) for PIO 0–4 and ceil(20 ns × clock) for PIO 5 (2 and 1 at 50 MHz). After a write the gap is 2.
- R7: IORDY waiting is enabled when the mode is above 2 or the device flags IORDY support. It is disabled when the device is CompactFlash and the mode is above 4.
- R8: With waiting enabled, each clock in which the synchronized IORDY is low holds the strobe low and freezes the pulse and cycle counts. With waiting disabled, IORDY has no effect.
- R9: After reset all card outputs are idle and `req_ready` is low. Timings are PIO 0 at `CLK_MHZ` (S=4, P=15, C=30, F=2 at 50 MHz) with waiting off.
- R10: A timing load during a cycle leaves that cycle's phases unchanged and applies from the next cycle.
- R11: A mode value above 5 behaves as mode 5.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Request pending |
| req_ready | output | 1 | One-clock acknowledge at cycle end |
| req_addr | input | 24 | Byte address within the card space |
| req_write | input | 1 | 1 = write, 0 = read |
| req_wide | input | 1 | 1 = 16-bit data register, 0 = 8-bit register |
| req_wdata | input | 16 | Write data |
| rsp_rdata | output | 16 | Captured read data |
| tcfg_load | input | 1 | Load timing set |
| tcfg_pio | input | 3 | PIO mode |
| tcfg_dev_iordy | input | 1 | Device reports IORDY support |
| tcfg_dev_cf | input | 1 | Device is CompactFlash |
| tcfg_setup | input | 8 | Setup clocks |
| tcfg_pulse | input | 8 | Strobe clocks |
| tcfg_cycle | input | 8 | Total cycle clocks |
| cf_cs0_n | output | 1 | Task-file window select |
| cf_cs1_n | output | 1 | Alternate window select |
| cf_reg | output | 3 | Register index |
| cf_wide | output | 1 | 16-bit access indicator |
| cf_rd_n | output | 1 | Read strobe |
| cf_wr_n | output | 1 | Write strobe |
| cf_dout | output | 16 | Card write data |
| cf_doe | output | 1 | Write data enable |
| cf_din | input | 16 | Card read data |
| cf_iordy | input | 1 | Card ready, asynchronous |

## Verification
The first stimulus set sweeps every setup count from 0 to 2 and every pulse count from 0 to 3. Each pair runs with a cycle count both shorter and longer than setup plus pulse, in both directions, widths and windows. This separates the phase counting from the cycle-length extension and from the zero-pulse rule. All unmapped mode codes are tried in both directions to prove that no select or strobe leaks out. The second set covers every combination of mode 0–7 and the two device flags. Each combination runs a read with IORDY held low, followed by a back-to-back write. The stretched or unstretched strobe shows the wait policy, and the gap shows the float count for each mode. Reads with late IORDY release, default timings after reset and a mid-cycle timing load finish the set. In every read the data on `cf_din` is correct only in the last strobe clock, so any off-by-one capture is exposed.

// File: rtl/cfide_pkg.sv
package cfide_pkg;

  typedef enum logic [2:0] {
    SQ_IDLE,
    SQ_SETUP,
    SQ_STROBE,
    SQ_HOLD,
    SQ_ACK,
    SQ_FLOAT
  } sq_state_t;

  typedef enum logic [1:0] {
    WIN_NONE,
    WIN_TASK,
    WIN_ALT
  } win_t;

  // clock count covering a time in ns, rounded up
  function automatic int unsigned ns_to_clk(input int unsigned ns, input int unsigned mhz);
    return (ns * mhz + 999) / 1000;
  endfunction

endpackage

// File: rtl/cfide_decode.sv
module cfide_decode
  import cfide_pkg::*;
#(
  parameter int AW = 24
) (
  input  logic [AW-1:0] addr,
  output win_t          win,
  output logic [2:0]    reg_idx
);
  localparam logic [2:0] MODE_TASK = 3'b110;
  localparam logic [2:0] MODE_ALT  = 3'b111;

  logic [2:0] mode_bits;
  logic       unused_mid;

  assign mode_bits  = addr[AW-1:AW-3];
  assign reg_idx    = addr[2:0];
  assign unused_mid = ^addr[AW-4:3];

  always_comb begin
    unique case (mode_bits)
      MODE_TASK: win = WIN_TASK;
      MODE_ALT:  win = WIN_ALT;
      default:   win = WIN_NONE;
    endcase
  end
endmodule

// File: rtl/cfide_timing_regs.sv
module cfide_timing_regs
  import cfide_pkg::*;
#(
  parameter int TW      = 8,
  parameter int CLK_MHZ = 50
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          load,
  input  logic [2:0]    pio,
  input  logic          dev_iordy,
  input  logic          dev_cf,
  input  logic [TW-1:0] setup_in,
  input  logic [TW-1:0] pulse_in,
  input  logic [TW-1:0] cycle_in,
  output logic [TW-1:0] t_setup,
  output logic [TW-1:0] t_pulse,
  output logic [TW-1:0] t_cycle,
  output logic [TW-1:0] t_float,
  output logic          t_wait
);
  localparam logic [TW-1:0] RST_SETUP = TW'(ns_to_clk(70, CLK_MHZ));
  localparam logic [TW-1:0] RST_PULSE = TW'(ns_to_clk(290, CLK_MHZ));
  localparam logic [TW-1:0] RST_CYCLE = TW'(ns_to_clk(600, CLK_MHZ));
  localparam logic [TW-1:0] FLOAT_SLOW = TW'(ns_to_clk(30, CLK_MHZ));
  localparam logic [TW-1:0] FLOAT_FAST = TW'(ns_to_clk(20, CLK_MHZ));
  localparam logic [2:0]    TOP_MODE   = 3'd5;

  logic [2:0]    pio_eff;
  logic          wait_calc;
  logic [TW-1:0] float_calc;
  logic [TW-1:0] pulse_fix;

  assign pio_eff    = (pio > TOP_MODE) ? TOP_MODE : pio;
  assign wait_calc  = ((pio_eff > 3'd2) || dev_iordy) && !(dev_cf && (pio_eff > 3'd4));
  assign float_calc = (pio_eff == TOP_MODE) ? FLOAT_FAST : FLOAT_SLOW;
  assign pulse_fix  = (pulse_in == '0) ? TW'(1) : pulse_in;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      t_setup <= RST_SETUP;
      t_pulse <= RST_PULSE;
      t_cycle <= RST_CYCLE;
      t_float <= FLOAT_SLOW;
      t_wait  <= 1'b0;
    end else if (load) begin
      t_setup <= setup_in;
      t_pulse <= pulse_fix;
      t_cycle <= cycle_in;
      t_float <= float_calc;
      t_wait  <= wait_calc;
    end
  end
endmodule

// File: rtl/cfide_iordy_sync.sv
module cfide_iordy_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic async_in,
  output logic sync_out
);
  logic [STAGES-1:0] chain;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) chain <= '1;
    else        chain <= {chain[STAGES-2:0], async_in};
  end

  assign sync_out = chain[STAGES-1];
endmodule

// File: rtl/cfide_sequencer.sv
module cfide_sequencer
  import cfide_pkg::*;
#(
  parameter int TW = 8,
  parameter int DW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          req_valid,
  input  win_t          win,
  input  logic [2:0]    reg_idx,
  input  logic          req_write,
  input  logic          req_wide,
  input  logic [DW-1:0] req_wdata,
  input  logic [TW-1:0] t_setup,
  input  logic [TW-1:0] t_pulse,
  input  logic [TW-1:0] t_cycle,
  input  logic [TW-1:0] t_float,
  input  logic          t_wait,
  input  logic          rdy_sync,
  input  logic [DW-1:0] cf_din,
  output logic          req_ready,
  output logic [DW-1:0] rsp_rdata,
  output logic          cs0_n,
  output logic          cs1_n,
  output logic [2:0]    cf_reg,
  output logic          cf_wide,
  output logic          rd_n,
  output logic          wr_n,
  output logic [DW-1:0] cf_dout,
  output logic          cf_doe
);
  localparam int XW = TW + 1;
  localparam int NB = DW / 2;

  sq_state_t     state;
  win_t          win_q;
  logic [2:0]    reg_q;
  logic          we_q;
  logic          wide_q;
  logic [DW-1:0] wdata_q;
  logic [TW-1:0] s_q, p_q, c_q, f_q;
  logic          wait_q;
  logic [TW-1:0] ph_cnt;
  logic [XW-1:0] elapsed;

  logic          active;
  logic          stall;
  logic [XW-1:0] ph_next;
  logic [XW-1:0] el_next;
  logic          cycle_used;
  logic [DW-1:0] din_fmt;

  assign active     = (state == SQ_SETUP) || (state == SQ_STROBE) || (state == SQ_HOLD);
  assign stall      = wait_q && !rdy_sync;
  assign ph_next    = {1'b0, ph_cnt} + XW'(1);
  assign el_next    = elapsed + XW'(1);
  assign cycle_used = (el_next >= {1'b0, c_q});
  assign din_fmt    = wide_q ? cf_din : {{(DW-NB){1'b0}}, cf_din[NB-1:0]};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state     <= SQ_IDLE;
      win_q     <= WIN_NONE;
      reg_q     <= '0;
      we_q      <= 1'b0;
      wide_q    <= 1'b0;
      wdata_q   <= '0;
      s_q       <= '0;
      p_q       <= '0;
      c_q       <= '0;
      f_q       <= '0;
      wait_q    <= 1'b0;
      ph_cnt    <= '0;
      elapsed   <= '0;
      rsp_rdata <= '0;
    end else begin
      unique case (state)
        SQ_IDLE: begin
          if (req_valid) begin
            win_q   <= win;
            reg_q   <= reg_idx;
            we_q    <= req_write;
            wide_q  <= req_wide;
            wdata_q <= req_wdata;
            s_q     <= t_setup;
            p_q     <= t_pulse;
            c_q     <= t_cycle;
            f_q     <= t_float;
            wait_q  <= t_wait;
            ph_cnt  <= '0;
            elapsed <= '0;
            if (win == WIN_NONE) begin
              state <= SQ_ACK;
              if (!req_write) rsp_rdata <= '0;
            end else if (t_setup == '0) begin
              state <= SQ_STROBE;
            end else begin
              state <= SQ_SETUP;
            end
          end
        end
        SQ_SETUP: begin
          elapsed <= el_next;
          if (ph_next == {1'b0, s_q}) begin
            ph_cnt <= '0;
            state  <= SQ_STROBE;
          end else begin
            ph_cnt <= ph_next[TW-1:0];
          end
        end
        SQ_STROBE: begin
          if (!stall) begin
            elapsed <= el_next;
            if (ph_next == {1'b0, p_q}) begin
              ph_cnt <= '0;
              if (!we_q) rsp_rdata <= din_fmt;
              state <= cycle_used ? SQ_ACK : SQ_HOLD;
            end else begin
              ph_cnt <= ph_next[TW-1:0];
            end
          end
        end
        SQ_HOLD: begin
          elapsed <= el_next;
          if (cycle_used) state <= SQ_ACK;
        end
        SQ_ACK: begin
          ph_cnt <= '0;
          if (!we_q && (win_q != WIN_NONE) && (f_q != '0)) state <= SQ_FLOAT;
          else                                             state <= SQ_IDLE;
        end
        SQ_FLOAT: begin
          if (ph_next == {1'b0, f_q}) state <= SQ_IDLE;
          else                        ph_cnt <= ph_next[TW-1:0];
        end
        default: state <= SQ_IDLE;
      endcase
    end
  end

  assign req_ready = (state == SQ_ACK);
  assign cs0_n     = !(active && (win_q == WIN_TASK));
  assign cs1_n     = !(active && (win_q == WIN_ALT));
  assign cf_reg    = reg_q;
  assign cf_wide   = active && wide_q;
  assign rd_n      = !((state == SQ_STROBE) && !we_q);
  assign wr_n      = !((state == SQ_STROBE) && we_q);
  assign cf_doe    = active && we_q;
  assign cf_dout   = wide_q ? wdata_q : {{(DW-NB){1'b0}}, wdata_q[NB-1:0]};
endmodule

// File: rtl/cfide_ctrl.sv
module cfide_ctrl
  import cfide_pkg::*;
#(
  parameter int AW      = 24,
  parameter int DW      = 16,
  parameter int TW      = 8,
  parameter int CLK_MHZ = 50
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          req_valid,
  output logic          req_ready,
  input  logic [AW-1:0] req_addr,
  input  logic          req_write,
  input  logic          req_wide,
  input  logic [DW-1:0] req_wdata,
  output logic [DW-1:0] rsp_rdata,
  input  logic          tcfg_load,
  input  logic [2:0]    tcfg_pio,
  input  logic          tcfg_dev_iordy,
  input  logic          tcfg_dev_cf,
  input  logic [TW-1:0] tcfg_setup,
  input  logic [TW-1:0] tcfg_pulse,
  input  logic [TW-1:0] tcfg_cycle,
  output logic          cf_cs0_n,
  output logic          cf_cs1_n,
  output logic [2:0]    cf_reg,
  output logic          cf_wide,
  output logic          cf_rd_n,
  output logic          cf_wr_n,
  output logic [DW-1:0] cf_dout,
  output logic          cf_doe,
  input  logic [DW-1:0] cf_din,
  input  logic          cf_iordy
);
  win_t          win;
  logic [2:0]    reg_idx;
  logic [TW-1:0] t_setup, t_pulse, t_cycle, t_float;
  logic          t_wait;
  logic          rdy_sync;

  cfide_decode #(.AW(AW)) u_decode (
    .addr    (req_addr),
    .win     (win),
    .reg_idx (reg_idx)
  );

  cfide_timing_regs #(.TW(TW), .CLK_MHZ(CLK_MHZ)) u_timing (
    .clk       (clk),
    .rst_n     (rst_n),
    .load      (tcfg_load),
    .pio       (tcfg_pio),
    .dev_iordy (tcfg_dev_iordy),
    .dev_cf    (tcfg_dev_cf),
    .setup_in  (tcfg_setup),
    .pulse_in  (tcfg_pulse),
    .cycle_in  (tcfg_cycle),
    .t_setup   (t_setup),
    .t_pulse   (t_pulse),
    .t_cycle   (t_cycle),
    .t_float   (t_float),
    .t_wait    (t_wait)
  );

  cfide_iordy_sync #(.STAGES(2)) u_sync (
    .clk      (clk),
    .rst_n    (rst_n),
    .async_in (cf_iordy),
    .sync_out (rdy_sync)
  );

  cfide_sequencer #(.TW(TW), .DW(DW)) u_seq (
    .clk       (clk),
    .rst_n     (rst_n),
    .req_valid (req_valid),
    .win       (win),
    .reg_idx   (reg_idx),
    .req_write (req_write),
    .req_wide  (req_wide),
    .req_wdata (req_wdata),
    .t_setup   (t_setup),
    .t_pulse   (t_pulse),
    .t_cycle   (t_cycle),
    .t_float   (t_float),
    .t_wait    (t_wait),
    .rdy_sync  (rdy_sync),
    .cf_din    (cf_din),
    .req_ready (req_ready),
    .rsp_rdata (rsp_rdata),
    .cs0_n     (cf_cs0_n),
    .cs1_n     (cf_cs1_n),
    .cf_reg    (cf_reg),
    .cf_wide   (cf_wide),
    .rd_n      (cf_rd_n),
    .wr_n      (cf_wr_n),
    .cf_dout   (cf_dout),
    .cf_doe    (cf_doe)
  );
endmodule

// File: rtl/cfide_ctrl_chk.sv
module cfide_ctrl_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       req_ready,
  input logic       cf_cs0_n,
  input logic       cf_cs1_n,
  input logic       cf_rd_n,
  input logic       cf_wr_n,
  input logic       cf_doe,
  input logic [2:0] cf_reg
);
  a_r1_single_window: assert property (@(posedge clk) disable iff (!rst_n)
    !(!cf_cs0_n && !cf_cs1_n));

  a_r4_single_strobe: assert property (@(posedge clk) disable iff (!rst_n)
    !(!cf_rd_n && !cf_wr_n));

  a_r3_strobe_inside_cs: assert property (@(posedge clk) disable iff (!rst_n)
    (!cf_rd_n || !cf_wr_n) |-> (!cf_cs0_n || !cf_cs1_n));

  a_r5_ready_one_clock: assert property (@(posedge clk) disable iff (!rst_n)
    req_ready |=> !req_ready);

  a_r5_ready_outside_cs: assert property (@(posedge clk) disable iff (!rst_n)
    req_ready |-> (cf_cs0_n && cf_cs1_n));

  a_r2_doe_not_on_read: assert property (@(posedge clk) disable iff (!rst_n)
    cf_doe |-> cf_rd_n);

  a_r1_reg_stable_in_strobe: assert property (@(posedge clk) disable iff (!rst_n)
    ((!cf_rd_n || !cf_wr_n) && $past(!cf_rd_n || !cf_wr_n)) |-> $stable(cf_reg));
endmodule

bind cfide_ctrl cfide_ctrl_chk u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .req_ready (req_ready),
  .cf_cs0_n  (cf_cs0_n),
  .cf_cs1_n  (cf_cs1_n),
  .cf_rd_n   (cf_rd_n),
  .cf_wr_n   (cf_wr_n),
  .cf_doe    (cf_doe),
  .cf_reg    (cf_reg)
);

// File: tb/cfide_ctrl_test.sv
`timescale 1ns/1ps
module cfide_ctrl_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req_valid = 1'b0;
  logic        req_ready;
  logic [23:0] req_addr = '0;
  logic        req_write = 1'b0;
  logic        req_wide = 1'b0;
  logic [15:0] req_wdata = '0;
  logic [15:0] rsp_rdata;
  logic        tcfg_load = 1'b0;
  logic [2:0]  tcfg_pio = '0;
  logic        tcfg_dev_iordy = 1'b0;
  logic        tcfg_dev_cf = 1'b0;
  logic [7:0]  tcfg_setup = '0;
  logic [7:0]  tcfg_pulse = '0;
  logic [7:0]  tcfg_cycle = '0;
  logic        cf_cs0_n, cf_cs1_n, cf_wide, cf_rd_n, cf_wr_n, cf_doe;
  logic [2:0]  cf_reg;
  logic [15:0] cf_dout;
  logic [15:0] cf_din = '0;
  logic        cf_iordy = 1'b1;

  int total = 0;
  int bad = 0;

  always #10 clk = ~clk;

  cfide_ctrl uut (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_addr(req_addr), .req_write(req_write), .req_wide(req_wide),
    .req_wdata(req_wdata), .rsp_rdata(rsp_rdata), .tcfg_load(tcfg_load),
    .tcfg_pio(tcfg_pio), .tcfg_dev_iordy(tcfg_dev_iordy), .tcfg_dev_cf(tcfg_dev_cf),
    .tcfg_setup(tcfg_setup), .tcfg_pulse(tcfg_pulse), .tcfg_cycle(tcfg_cycle),
    .cf_cs0_n(cf_cs0_n), .cf_cs1_n(cf_cs1_n), .cf_reg(cf_reg), .cf_wide(cf_wide),
    .cf_rd_n(cf_rd_n), .cf_wr_n(cf_wr_n), .cf_dout(cf_dout), .cf_doe(cf_doe),
    .cf_din(cf_din), .cf_iordy(cf_iordy)
  );

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s act=%0d exp=%0d", tag, act, exp);
    end
  endtask

  task automatic load_cfg(input int pio, input bit dio, input bit dcf,
                          input int s, input int p, input int c);
    tcfg_pio = 3'(pio); tcfg_dev_iordy = dio; tcfg_dev_cf = dcf;
    tcfg_setup = 8'(s); tcfg_pulse = 8'(p); tcfg_cycle = 8'(c);
    tcfg_load = 1'b1;
    @(negedge clk);
    tcfg_load = 1'b0;
  endtask

  task automatic finish_req(input bit iordy_next);
    @(negedge clk);
    req_valid = 1'b0;
    cf_iordy = iordy_next;
    repeat (5) @(negedge clk);
  endtask

  // presents a request at the current negedge and observes until req_ready
  task automatic run_cycle(input logic [23:0] addr, input bit we, input bit wide,
                           input logic [15:0] wd, input logic [15:0] di,
                           input int exp_s, input int exp_p, input int exp_cs,
                           input int rel_j, input bit mid_load,
                           output int gap, output int n_str, output int n_cs);
    int n_pre, sel_bad, reg_bad, wide_bad, stb_bad, out_bad, hole;
    bit got, mapped, alt, lo;
    logic [15:0] rd_got, exp_out, exp_rd;
    mapped = (addr[23:22] == 2'b11);
    alt = addr[21];
    exp_out = wide ? wd : {8'h00, wd[7:0]};
    exp_rd = !mapped ? 16'h0000 : (wide ? di : {8'h00, di[7:0]});
    req_addr = addr; req_write = we; req_wide = wide; req_wdata = wd;
    req_valid = 1'b1; cf_din = ~di;
    gap = 0; n_str = 0; n_cs = 0; n_pre = 0; got = 0; rd_got = '0;
    sel_bad = 0; reg_bad = 0; wide_bad = 0; stb_bad = 0; out_bad = 0; hole = 0;
    for (int k = 0; k < 400 && !got; k++) begin
      @(negedge clk);
      if (mid_load) tcfg_load = (k == 1);
      lo = !cf_cs0_n || !cf_cs1_n;
      if (req_ready) begin
        got = 1;
        rd_got = rsp_rdata;
        chk(cf_cs0_n && cf_cs1_n && cf_rd_n && cf_wr_n, "R5", {cf_cs0_n, cf_cs1_n}, 3);
      end else if (!lo) begin
        if (n_cs == 0) gap++;
        else hole++;
        if (!cf_rd_n || !cf_wr_n) stb_bad++;
      end else begin
        n_cs++;
        if (cf_cs0_n != alt || cf_cs1_n != !alt) sel_bad++;
        if (cf_reg != addr[2:0]) reg_bad++;
        if (cf_wide != wide) wide_bad++;
        if (!we && cf_doe) out_bad++;
        if (!cf_rd_n || !cf_wr_n) begin
          if (n_str == 0) n_pre = n_cs - 1;
          n_str++;
          if (we && (!cf_rd_n || cf_wr_n)) stb_bad++;
          if (!we && (!cf_wr_n || cf_rd_n)) stb_bad++;
          if (we && (cf_dout != exp_out || !cf_doe)) out_bad++;
          if (rel_j > 0 && n_str == rel_j) cf_iordy = 1'b1;
          cf_din = (n_str == exp_p) ? di : ~di;
        end else begin
          cf_din = ~di;
        end
      end
    end
    tcfg_load = 1'b0;
    chk(got, "R5 ready seen", int'(got), 1);
    chk(hole == 0, "R3 select continuous", hole, 0);
    chk(n_cs == exp_cs, "R3 select width", n_cs, exp_cs);
    chk(n_pre == exp_s, "R4 setup", n_pre, exp_s);
    chk(n_str == exp_p, "R4 strobe width", n_str, exp_p);
    chk(stb_bad == 0, "R4 strobe kind", stb_bad, 0);
    chk(sel_bad == 0, "R1 window select", sel_bad, 0);
    chk(reg_bad == 0, "R1 register index", reg_bad, 0);
    chk(wide_bad == 0, "R2 width flag", wide_bad, 0);
    chk(out_bad == 0, "R2 write data", out_bad, 0);
    if (!we) chk(rd_got == exp_rd, "R5 read data", int'(rd_got), int'(exp_rd));
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    total++;
    bad++;
    $display("FAIL watchdog act=1 exp=0");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    int g, ns, nc, g2, ns2, nc2;
    repeat (3) @(negedge clk);
    chk(cf_cs0_n && cf_cs1_n && cf_rd_n && cf_wr_n && !req_ready && !cf_doe,
        "R9 idle in reset", 0, 0);
    rst_n = 1'b1;
    cf_iordy = 1'b0;
    repeat (4) @(negedge clk);
    chk(cf_cs0_n && cf_cs1_n && cf_rd_n && cf_wr_n && !req_ready && !cf_doe,
        "R9 idle after reset", 0, 0);

    // R9 defaults: PIO 0 at 50 MHz, IORDY ignored
    run_cycle({3'b110, 18'h0, 3'd0}, 0, 1, 16'h0, 16'hBEEF, 4, 15, 30, 3, 0, g, ns, nc);
    chk(ns == 15, "R9 default pulse, iordy off", ns, 15);
    @(negedge clk);
    run_cycle({3'b110, 18'h0, 3'd1}, 1, 0, 16'h1234, 16'h0, 4, 15, 30, 0, 0, g, ns, nc);
    chk(g + 2 == 4, "R9 default float", g + 2, 4);
    finish_req(1'b1);

    // R3/R4 sweep over setup, pulse, cycle, direction, width, window
    for (int s = 0; s < 3; s++) begin
      for (int p = 0; p < 4; p++) begin
        for (int cm = 0; cm < 2; cm++) begin
          for (int we = 0; we < 2; we++) begin
            int pe, c, cs;
            logic [2:0] mb, ri;
            logic [15:0] pat;
            pe = (p == 0) ? 1 : p;
            c = cm ? (s + pe + 2) : 0;
            cs = (c > s + pe) ? c : s + pe;
            mb = ((p + cm) % 2 == 1) ? 3'b111 : 3'b110;
            ri = 3'((s * 3 + p + we) % 8);
            pat = 16'hA5C3 ^ 16'((s * 16 + p * 4 + cm * 2 + we) * 16'h1357);
            load_cfg(0, 0, 0, s, p, c);
            run_cycle({mb, 18'h2AAAA, ri}, we[0], 1'((s + we + cm) % 2), pat, ~pat,
                      s, pe, cs, 0, 0, g, ns, nc);
            finish_req(1'b1);
          end
        end
      end
    end

    // R1: unmapped mode codes touch nothing on the card side
    load_cfg(0, 0, 0, 1, 2, 4);
    for (int m = 0; m < 6; m++) begin
      for (int we = 0; we < 2; we++) begin
        run_cycle({3'(m), 18'h3FFFF, 3'd5}, we[0], 1, 16'hCAFE, 16'h7E7E, 0, 0, 0, 0, 0, g, ns, nc);
        chk(nc == 0 && ns == 0, "R1 unmapped no select", nc + ns, 0);
        finish_req(1'b1);
      end
    end

    // R7/R11/R6: every mode and device flag combination
    for (int pio = 0; pio < 8; pio++) begin
      for (int dio = 0; dio < 2; dio++) begin
        for (int dcf = 0; dcf < 2; dcf++) begin
          int pe, ep, ef;
          bit en;
          pe = (pio > 5) ? 5 : pio;
          en = ((pe > 2) || (dio == 1)) && !((dcf == 1) && (pe > 4));
          ep = en ? 4 : 2;
          ef = (pe == 5) ? 1 : 2;
          load_cfg(pio, dio[0], dcf[0], 1, 2, 0);
          finish_req(1'b0);
          run_cycle({3'b111, 18'h0, 3'd6}, 0, 1, 16'h0, 16'h5AA5 ^ 16'(pio),
                    1, ep, 1 + ep, 1, 0, g, ns, nc);
          if (pio > 5) chk(ns == ep, "R11 mode clamp", ns, ep);
          else         chk(ns == ep, "R7 wait policy", ns, ep);
          @(negedge clk);
          run_cycle({3'b110, 18'h0, 3'd2}, 1, 1, 16'h0F0F, 16'h0, 1, 2, 3, 0, 0, g2, ns2, nc2);
          chk(g2 + 2 == ef + 2, "R6 float after read", g2 + 2, ef + 2);
          @(negedge clk);
          run_cycle({3'b110, 18'h0, 3'd3}, 1, 0, 16'h00F0, 16'h0, 1, 2, 3, 0, 0, g2, ns2, nc2);
          chk(g2 + 2 == 2, "R6 gap after write", g2 + 2, 2);
          finish_req(1'b1);
        end
      end
    end

    // R8: late IORDY release stretches strobe and cycle
    load_cfg(3, 0, 0, 2, 3, 10);
    finish_req(1'b0);
    run_cycle({3'b110, 18'h0, 3'd7}, 0, 1, 16'h0, 16'h9C3D, 2, 6, 13, 2, 0, g, ns, nc);
    chk(ns == 6 && nc == 13, "R8 wait two", ns * 100 + nc, 613);
    finish_req(1'b0);
    run_cycle({3'b111, 18'h0, 3'd4}, 1, 1, 16'h6E21, 16'h0, 2, 9, 16, 5, 0, g, ns, nc);
    chk(ns == 9 && nc == 16, "R8 wait five", ns * 100 + nc, 916);
    finish_req(1'b1);

    // R10: load during a cycle applies only afterwards
    load_cfg(0, 0, 0, 2, 3, 12);
    finish_req(1'b1);
    tcfg_setup = 8'd1; tcfg_pulse = 8'd1; tcfg_cycle = 8'd0;
    run_cycle({3'b110, 18'h0, 3'd1}, 0, 0, 16'h0, 16'h00C4, 2, 3, 12, 0, 1, g, ns, nc);
    chk(nc == 12, "R10 current cycle keeps timing", nc, 12);
    finish_req(1'b1);
    run_cycle({3'b110, 18'h0, 3'd1}, 0, 0, 16'h0, 16'h3311, 1, 1, 2, 0, 0, g, ns, nc);
    chk(nc == 2 && ns == 1, "R10 next cycle uses new timing", nc * 10 + ns, 21);
    finish_req(1'b1);

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule